// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers seven event sources into sticky pending flags and drives one active-low interrupt request line to a host processor. The request line goes low while any flag is pending. The host finds out which source raised the request by pulsing a status-read strobe. That strobe copies the flags into a status register and clears the pending set in the same cycle.

Two enables qualify some of the sources. FIFO events count only while the FIFO is enabled, and transmit-register events count only while the transmit register is enabled. An external, asynchronous interrupt pin is synchronized, and its falling edges are caught. The power-on flag is pending as the block leaves reset, so the host is interrupted straight after power-up. A priority encoder also reports the lowest-numbered pending source, which lets the host service sources in a fixed order.

Top module: `irq_aggregator`

## Requirements
- R1: `irq_n` is 0 while at least one flag is pending and 1 when no flag is pending.
- R2: Flag bit map: bit0 transmit ready, bit1 FIFO threshold, bit2 power-on, bit3 FIFO overflow or transmit underrun, bit4 wake-up timeout, bit5 external pin, bit6 low supply. On a cycle with `status_rd`=1, `status` loads the flags as they stood before that clock edge, and the new value is visible after the edge.
- R3: `ev_fifo_thr` and `ev_fifo_ovf` set no flag while `fifo_en`=0.
- R4: `ev_tx_ready` and `ev_tx_urun` set no flag while `txreg_en`=0.
- R5: After reset, only the power-on flag is pending. `irq_n` is therefore 0 from the first cycle, and `status` reads 0 until the first read.
- R6: A falling edge on `ext_int_n` sets bit5 at the third rising clock edge after the fall (SYNC_STAGES=2). A rising edge or a steady level sets nothing.
- R7: A pending flag stays set, with no source active, until a status read.
- R8: A status read clears every flag. Any source active in the read cycle leaves its flag set afterwards, so a level condition that still holds reasserts its flag.
- R9: `top_src` gives the index of the lowest-numbered pending flag, and 7 when no flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_ready | input | 1 | Transmit register can take the next byte (level) |
| ev_fifo_thr | input | 1 | FIFO holds the programmed bit count (level) |
| ev_fifo_ovf | input | 1 | FIFO overflow event |
| ev_tx_urun | input | 1 | Transmit register underrun event |
| ev_wake | input | 1 | Wake-up timer timeout event |
| ev_low_supply | input | 1 | Supply below threshold (level) |
| fifo_en | input | 1 | FIFO enabled |
| txreg_en | input | 1 | Transmit register enabled |
| ext_int_n | input | 1 | Asynchronous external interrupt pin, active low |
| status_rd | input | 1 | Status-read strobe, one cycle |
| status | output | 7 | Flags captured at the last read |
| top_src | output | 3 | Lowest-numbered pending flag, 7 when none |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions take two things for granted. First, every event input and enable is synchronous to `clk`. Second, `status_rd` is sampled only at clock edges and is never needed longer than one cycle per read. The bench drives every synchronous input on the falling clock edge, so each input is stable at the sampling edge. Only `ext_int_n` is treated as asynchronous, and the bench still moves it away from the rising edge, so the latency of the edge detector is deterministic.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx_ready,
  input  logic       ev_fifo_thr,
  input  logic       ev_fifo_ovf,
  input  logic       ev_tx_urun,
  input  logic       ev_wake,
  input  logic       ev_low_supply,
  input  logic       fifo_en,
  input  logic       txreg_en,
  input  logic       ext_int_n,
  input  logic       status_rd,
  output logic [6:0] status,
  output logic [2:0] top_src,
  output logic       irq_n
);
  localparam int NSRC = 7;
  localparam logic [NSRC-1:0] RST_FLAGS = NSRC'(1) << 2;

  logic [SYNC_STAGES:0] ext_pipe;
  logic                 ext_fall;
  logic [NSRC-1:0]      set_vec;
  logic [NSRC-1:0]      flags;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_pipe <= '1;
    else        ext_pipe <= {ext_pipe[SYNC_STAGES-1:0], ext_int_n};

  assign ext_fall = ext_pipe[SYNC_STAGES] & ~ext_pipe[SYNC_STAGES-1];

  assign set_vec = {ev_low_supply,
                    ext_fall,
                    ev_wake,
                    (ev_fifo_ovf & fifo_en) | (ev_tx_urun & txreg_en),
                    1'b0,
                    ev_fifo_thr & fifo_en,
                    ev_tx_ready & txreg_en};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags  <= RST_FLAGS;
      status <= '0;
    end else begin
      flags <= (status_rd ? '0 : flags) | set_vec;
      if (status_rd) status <= flags;
    end

  always_comb begin
    top_src = 3'd7;
    for (int i = NSRC - 1; i >= 0; i--)
      if (flags[i]) top_src = 3'(i);
  end

  assign irq_n = ~|flags;
endmodule

module irq_aggregator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       status_rd,
  input logic       fifo_en,
  input logic       txreg_en,
  input logic       irq_n,
  input logic [6:0] status,
  input logic [2:0] top_src,
  input logic [6:0] flags,
  input logic [6:0] set_vec
);
  logic first_cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) first_cyc <= 1'b1;
    else        first_cyc <= 1'b0;

  p_por_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    first_cyc |-> !irq_n);

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> status == $past(flags));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd |=> ($past(flags) & ~flags) == 7'd0);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> flags == $past(set_vec));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !txreg_en && !status_rd && flags[1:0] == 2'b00 && !flags[3])
      |=> (flags[1:0] == 2'b00 && !flags[3]));

  p_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (top_src == 3'd7) == irq_n);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk, .rst_n, .status_rd, .fifo_en, .txreg_en, .irq_n, .status, .top_src,
  .flags(flags), .set_vec(set_vec)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_ready = 0, ev_fifo_thr = 0, ev_fifo_ovf = 0, ev_tx_urun = 0;
  logic ev_wake = 0, ev_low_supply = 0, fifo_en = 0, txreg_en = 0;
  logic ext_int_n = 1, status_rd = 0;
  logic [6:0] status;
  logic [2:0] top_src;
  logic irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_aggregator dut (
    .clk, .rst_n, .ev_tx_ready, .ev_fifo_thr, .ev_fifo_ovf, .ev_tx_urun,
    .ev_wake, .ev_low_supply, .fifo_en, .txreg_en, .ext_int_n, .status_rd,
    .status, .top_src, .irq_n
  );

  // {tx_ready, fifo_thr, ovf, urun, wake, low, fifo_en, txreg_en}, expected flags, expected top_src
  localparam logic [17:0] VEC [10] = '{
    {8'b1111_1111, 7'h5B, 3'd0},
    {8'b1111_1100, 7'h50, 3'd4},
    {8'b1111_1110, 7'h5A, 3'd1},
    {8'b1111_1101, 7'h59, 3'd0},
    {8'b0001_0010, 7'h00, 3'd7},
    {8'b0001_0001, 7'h08, 3'd3},
    {8'b0010_0010, 7'h08, 3'd3},
    {8'b0000_1000, 7'h10, 3'd4},
    {8'b0000_0100, 7'h40, 3'd6},
    {8'b0100_0001, 7'h00, 3'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {ev_tx_ready, ev_fifo_thr, ev_fifo_ovf, ev_tx_urun,
     ev_wake, ev_low_supply, fifo_en, txreg_en} = v;
  endtask

  task automatic do_read();
    @(negedge clk) status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 irq after reset", 32'(irq_n), 0);
    chk("R5 status after reset", 32'(status), 0);
    chk("R9 top_src after reset", 32'(top_src), 2);
    do_read();
    chk("R2 R5 por flag read", 32'(status), 32'h04);
    chk("R1 irq cleared", 32'(irq_n), 1);
    chk("R9 none pending", 32'(top_src), 7);

    foreach (VEC[i]) begin
      @(negedge clk) drive(VEC[i][17:10]);
      @(negedge clk) drive(8'h00);
      chk("R1 R3 R4 irq after events", 32'(irq_n), 32'(VEC[i][9:3] == 7'h00));
      chk("R9 top_src", 32'(top_src), 32'(VEC[i][2:0]));
      status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
      chk("R2 R3 R4 status", 32'(status), 32'(VEC[i][9:3]));
      chk("R8 irq after read", 32'(irq_n), 1);
    end

    // R6: falling edge latency, then rising edge has no effect
    ext_int_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not yet after two edges", 32'(irq_n), 1);
    @(negedge clk);
    chk("R6 set at third edge", 32'(irq_n), 0);
    chk("R6 R9 top_src ext", 32'(top_src), 5);
    do_read();
    chk("R6 status ext bit", 32'(status), 32'h20);
    ext_int_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 rising edge ignored", 32'(irq_n), 1);
    do_read();
    chk("R6 status after rise", 32'(status), 0);

    // R7: sticky
    @(negedge clk) ev_wake = 1'b1;
    @(negedge clk) ev_wake = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 flag held", 32'(irq_n), 0);

    // R8: event in read cycle stays set
    ev_wake = 1'b1; ev_fifo_ovf = 1'b1; fifo_en = 1'b1; status_rd = 1'b1;
    @(negedge clk);
    ev_wake = 1'b0; ev_fifo_ovf = 1'b0; fifo_en = 1'b0; status_rd = 1'b0;
    chk("R8 captured before same-cycle event", 32'(status), 32'h10);
    chk("R8 same-cycle event pending", 32'(irq_n), 0);
    do_read();
    chk("R8 same-cycle event read", 32'(status), 32'h18);
    chk("R8 cleared", 32'(irq_n), 1);

    // R8: level condition reasserts
    @(negedge clk) ev_low_supply = 1'b1;
    do_read();
    chk("R8 level read", 32'(status), 32'h40);
    chk("R8 level reasserts", 32'(irq_n), 0);
    ev_low_supply = 1'b0;
    do_read();
    chk("R8 level gone", 32'(irq_n), 1);

    // R3: FIFO threshold held high with FIFO disabled
    ev_fifo_thr = 1'b1; txreg_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 held threshold ignored", 32'(irq_n), 1);
    ev_fifo_thr = 1'b0; txreg_en = 1'b0;

    finish_run();
  end
endmodule